// File: doc/BRIEF.md
# ISA I/O Read Width Splitter

This block sits on the host side of an ISA-style I/O bus and carries out one 16-bit I/O read for the CPU. It drives the address, runs the read strobe and then decides how wide the cycle is. The device's 16-bit acknowledge input is looked at exactly once, one clock after the address goes out, and that one sample fixes the mode for the whole transaction. If the device acknowledges, the block reads both byte lanes in one strobe. If it does not, the block runs two narrow strobes on the low byte lane. The first is at the base address and the second at base+1. The two bytes are joined into one word only when the transaction ends.

The CPU side is a simple request/ready pair. The CPU holds the address and raises `cpu_req` while the block is idle. One clock after the final byte has been captured, the block answers with a single-cycle `cpu_ready` pulse, and the assembled word appears on `cpu_rdata` at the same time. The strobe length, the idle gap between split cycles, the address width, the lane width and the asserted level of the acknowledge input are all parameters.

Top module: `isa_rd_splitter`

## Requirements
- R1: While reset is held, `bus_ior_n` is 1, `cpu_ready` is 0 and `cpu_rdata` is 0, whatever `cpu_req` does.
- R2: The width is chosen from `bus_io16` as it stands in the single clock after the address becomes valid. That clock is the cycle right after the edge that accepts `cpu_req`. The level of `bus_io16` before that clock has no effect.
- R3: If the sample shows the acknowledge asserted (low with the default `IO16_ACTIVE_LOW`=1), the block runs exactly one strobe at the base address. `cpu_rdata` then equals the full `bus_data` word present at the end of that strobe.
- R4: If the sample shows the acknowledge negated, the block runs exactly two strobes. The first is at the base address and the second at base+1. `bus_addr` stays stable throughout every strobe.
- R5: In a split read, both bytes come from `bus_data[LANE_W-1:0]`. The upper lane is ignored.
- R6: In a split read, the byte from the base address goes to `cpu_rdata[LANE_W-1:0]` and the byte from base+1 goes to `cpu_rdata[2*LANE_W-1:LANE_W]`.
- R7: A change of `bus_io16` after the sample clock has no effect. The transaction finishes in the sampled mode.
- R8: Every strobe holds `bus_ior_n` low for exactly `STROBE_CLKS` clocks.
- R9: The two strobes of a split read are separated by exactly `GAP_CLKS` clocks with `bus_ior_n` high.
- R10: `cpu_ready` is a one-clock pulse, and `bus_ior_n` is high while it is asserted. Counting the accepting edge as edge 0, the pulse appears after edge `1+STROBE_CLKS` for a 16-bit read and after edge `1+2*STROBE_CLKS+GAP_CLKS` for a split read.
- R11: `cpu_req` is ignored while a transaction is in progress. Holding it high for the whole transaction starts no extra strobe and gives no extra ready pulse.
- R12: The base+1 address wraps modulo 2^`ADDR_W`, so a split read at the highest address fetches its second byte from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Read request, accepted while idle |
| cpu_addr | input | ADDR_W | Base I/O address of the read |
| cpu_rdata | output | 2*LANE_W | Assembled read word, updated with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_addr | output | ADDR_W | Bus address, base or base+1 |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_data | input | 2*LANE_W | Bus data, both byte lanes |
| bus_io16 | input | 1 | Device 16-bit acknowledge, level set by `IO16_ACTIVE_LOW` |

## Verification
If the held mode bit is wrong, the fault shows up at the ports within the same transaction. The number of strobes is wrong, and `cpu_ready` arrives `STROBE_CLKS+GAP_CLKS` clocks early or late. A phase or steering error does not change the timing. It shows up only in `cpu_rdata`, as a byte in the wrong lane or a byte taken from the unused upper lane. The bench therefore gives every address a distinct upper-lane value. A counter error stretches or shortens a strobe or the gap at the very next strobe. Every transaction drives the opposite acknowledge level before the sample clock and flips it after, so a sample taken one clock early or late changes the mode at once.

// File: rtl/isa_split_pkg.sv
package isa_split_pkg;

   typedef enum logic [1:0] {
      SPL_IDLE = 2'd0,
      SPL_ADDR = 2'd1,
      SPL_STRB = 2'd2,
      SPL_GAP  = 2'd3
   } spl_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/isa_split_seq.sv
module isa_split_seq
   import isa_split_pkg::*;
#(
   parameter int STROBE_CLKS = 3,
   parameter int GAP_CLKS    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       io16_hit_i,
   output spl_state_e state_o,
   output logic       second_o,
   output logic       wide_o,
   output logic       cap_first_o,
   output logic       done_o
);

   localparam int CNT_MAX = max_of(STROBE_CLKS, GAP_CLKS);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STROBE_CLKS - 1);
   localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CLKS - 1);

   spl_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             second_q;
   logic             wide_q;
   logic             strb_end;

   assign strb_end = (state_q == SPL_STRB) && (cnt_q == STRB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SPL_IDLE;
         cnt_q    <= '0;
         second_q <= 1'b0;
         wide_q   <= 1'b0;
      end else begin
         case (state_q)
            SPL_IDLE: begin
               if (start_i) begin
                  state_q  <= SPL_ADDR;
                  second_q <= 1'b0;
               end
            end
            SPL_ADDR: begin
               // single sample point: one clock after the address is driven
               wide_q  <= io16_hit_i;
               cnt_q   <= '0;
               state_q <= SPL_STRB;
            end
            SPL_STRB: begin
               if (cnt_q == STRB_LAST) begin
                  cnt_q <= '0;
                  if (wide_q || second_q) begin
                     state_q <= SPL_IDLE;
                  end else begin
                     state_q  <= SPL_GAP;
                     second_q <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SPL_GAP: begin
               if (cnt_q == GAP_LAST) begin
                  cnt_q   <= '0;
                  state_q <= SPL_STRB;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= SPL_IDLE;
         endcase
      end
   end

   assign state_o     = state_q;
   assign second_o    = second_q;
   assign wide_o      = wide_q;
   assign cap_first_o = strb_end && !second_q;
   assign done_o      = strb_end && (wide_q || second_q);

endmodule

// File: rtl/isa_split_addr.sv
module isa_split_addr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              second_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (load_i) begin
         base_q <= base_i;
      end
   end

   // base+1 wraps modulo 2^ADDR_W
   assign addr_o = base_q + ADDR_W'(second_i);

endmodule

// File: rtl/isa_split_asm.sv
module isa_split_asm #(
   parameter int LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_first_i,
   input  logic                done_i,
   input  logic                wide_i,
   input  logic [2*LANE_W-1:0] bus_data_i,
   output logic [2*LANE_W-1:0] rdata_o
);

   localparam int NUM_LANES = 2;

   logic [LANE_W-1:0] lo_hold_q;
   logic [LANE_W-1:0] low_lane;

   assign low_lane = bus_data_i[LANE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_hold_q <= '0;
      end else if (cap_first_i) begin
         lo_hold_q <= low_lane;
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      logic [LANE_W-1:0] lane_nxt;

      if (g == 0) begin : g_low
         assign lane_nxt = wide_i ? bus_data_i[LANE_W-1:0] : lo_hold_q;
      end else begin : g_high
         assign lane_nxt = wide_i ? bus_data_i[2*LANE_W-1:LANE_W] : low_lane;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (done_i) begin
            lane_q <= lane_nxt;
         end
      end

      assign rdata_o[g*LANE_W +: LANE_W] = lane_q;
   end

endmodule

// File: rtl/isa_rd_splitter.sv
module isa_rd_splitter
   import isa_split_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int LANE_W          = 8,
   parameter int STROBE_CLKS     = 3,
   parameter int GAP_CLKS        = 1,
   parameter bit IO16_ACTIVE_LOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic [ADDR_W-1:0]   cpu_addr,
   output logic [2*LANE_W-1:0] cpu_rdata,
   output logic                cpu_ready,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                bus_ior_n,
   input  logic [2*LANE_W-1:0] bus_data,
   input  logic                bus_io16
);

   localparam int LO_RUN_W = $clog2(STROBE_CLKS + 1) + 1;
   localparam int HI_RUN_W = $clog2(GAP_CLKS + 1) + 1;

   if (STROBE_CLKS < 1) begin : g_bad_strobe
      $error("STROBE_CLKS must be at least 1");
   end
   if (GAP_CLKS < 1) begin : g_bad_gap
      $error("GAP_CLKS must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   spl_state_e state;
   logic       second;
   logic       wide;
   logic       cap_first;
   logic       done;
   logic       start;
   logic       io16_hit;

   if (IO16_ACTIVE_LOW) begin : g_io16_low
      assign io16_hit = !bus_io16;
   end else begin : g_io16_high
      assign io16_hit = bus_io16;
   end

   assign start = cpu_req && (state == SPL_IDLE);

   isa_split_seq #(
      .STROBE_CLKS (STROBE_CLKS),
      .GAP_CLKS    (GAP_CLKS)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .io16_hit_i  (io16_hit),
      .state_o     (state),
      .second_o    (second),
      .wide_o      (wide),
      .cap_first_o (cap_first),
      .done_o      (done)
   );

   isa_split_addr #(
      .ADDR_W (ADDR_W)
   ) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start),
      .base_i   (cpu_addr),
      .second_i (second),
      .addr_o   (bus_addr)
   );

   isa_split_asm #(
      .LANE_W (LANE_W)
   ) i_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_first_i (cap_first),
      .done_i      (done),
      .wide_i      (wide),
      .bus_data_i  (bus_data),
      .rdata_o     (cpu_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_ready <= 1'b0;
      end else begin
         cpu_ready <= done;
      end
   end

   assign bus_ior_n = (state != SPL_STRB);

   // run-length counters of the strobe line, used by the checks below
   logic [LO_RUN_W-1:0] lo_run_q;
   logic [HI_RUN_W-1:0] hi_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run_q <= '0;
         hi_run_q <= '0;
      end else if (bus_ior_n) begin
         lo_run_q <= '0;
         if (hi_run_q != {HI_RUN_W{1'b1}}) hi_run_q <= hi_run_q + HI_RUN_W'(1);
      end else begin
         hi_run_q <= '0;
         if (lo_run_q != {LO_RUN_W{1'b1}}) lo_run_q <= lo_run_q + LO_RUN_W'(1);
      end
   end

   assert_strobe_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ior_n) |-> (lo_run_q == LO_RUN_W'(STROBE_CLKS)));

   assert_split_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_ior_n) && second) |-> (hi_run_q == HI_RUN_W'(GAP_CLKS)));

   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   assert_ready_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> bus_ior_n);

   assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ior_n && !$past(bus_ior_n)) |-> $stable(bus_addr));

endmodule

// File: tb/test_isa_rd_splitter.sv
module test_isa_rd_splitter;

   localparam int AW   = 6;
   localparam int LW   = 8;
   localparam int SCLK = 2;
   localparam int GCLK = 2;
   localparam int LAT_WIDE   = 2 + SCLK;
   localparam int LAT_NARROW = 2 + 2 * SCLK + GCLK;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [15:0]   cpu_rdata;
   logic          cpu_ready;
   logic [AW-1:0] bus_addr;
   logic          bus_ior_n;
   logic [15:0]   bus_data;
   logic          bus_io16 = 1'b1;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   function automatic logic [15:0] dev_word(input logic [AW-1:0] a);
      logic [7:0] x;
      x = 8'(a);
      return {(x * 8'd5) ^ 8'hC3, x * 8'd3 + 8'h11};
   endfunction

   assign bus_data = !bus_ior_n ? dev_word(bus_addr) : 16'h0F0F;

   isa_rd_splitter #(
      .ADDR_W      (AW),
      .LANE_W      (LW),
      .STROBE_CLKS (SCLK),
      .GAP_CLKS    (GCLK)
   ) i_isa_rd_splitter (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_addr  (cpu_addr),
      .cpu_rdata (cpu_rdata),
      .cpu_ready (cpu_ready),
      .bus_addr  (bus_addr),
      .bus_ior_n (bus_ior_n),
      .bus_data  (bus_data),
      .bus_io16  (bus_io16)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_tx(input int a, input bit wide, input bit flip, input bit hold);
      int n, nstrb, cur_lo, cur_hi, gap;
      bit prev, lo_bad, flipped, got;
      logic [AW-1:0] addr0, addr1, a1;
      logic [15:0] w0, w1, expd;
      string tag;
      n = 0; nstrb = 0; cur_lo = 0; cur_hi = 0; gap = -1;
      prev = 1'b1; lo_bad = 1'b0; flipped = 1'b0; got = 1'b0;
      addr0 = '0; addr1 = '0;
      @(negedge clk);
      bus_io16 = wide ? 1'b1 : 1'b0;   // opposite level before the sample clock
      cpu_addr = AW'(a);
      cpu_req = 1'b1;
      while (!got && n < 60) begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            bus_io16 = wide ? 1'b0 : 1'b1;
            if (!hold) cpu_req = 1'b0;
         end
         if (!bus_ior_n) begin
            if (prev) begin
               nstrb++;
               if (nstrb == 1) addr0 = bus_addr;
               else begin
                  addr1 = bus_addr;
                  gap = cur_hi;
               end
               cur_lo = 0;
               if (flip && !flipped) begin
                  bus_io16 = ~bus_io16;
                  flipped = 1'b1;
               end
            end
            cur_lo++;
         end else begin
            if (!prev) begin
               if (cur_lo != SCLK) lo_bad = 1'b1;
               cur_hi = 0;
            end
            cur_hi++;
         end
         prev = bus_ior_n;
         if (cpu_ready) got = 1'b1;
      end
      cpu_req = 1'b0;
      a1 = AW'(a + 1);
      w0 = dev_word(AW'(a));
      w1 = dev_word(a1);
      expd = wide ? w0 : {w1[7:0], w0[7:0]};
      check(got, "R10 ready timeout", got, 1);
      check(n == (wide ? LAT_WIDE : LAT_NARROW), "R10 latency", n, wide ? LAT_WIDE : LAT_NARROW);
      check(nstrb == (wide ? 1 : 2), wide ? "R3 strobe count" : "R4 strobe count", nstrb, wide ? 1 : 2);
      check(addr0 == AW'(a), "R4 first address", addr0, a);
      check(!lo_bad, "R8 strobe length", cur_lo, SCLK);
      if (!wide) begin
         check(addr1 == a1, (a == (1 << AW) - 1) ? "R12 wrapped address" : "R4 second address", addr1, a1);
         check(gap == GCLK, "R9 gap length", gap, GCLK);
      end
      if (flip) tag = "R7 late io16 change";
      else if (wide) tag = "R2/R3 wide data";
      else tag = "R2/R5/R6 split data";
      check(cpu_rdata == expd, tag, cpu_rdata, expd);
      @(negedge clk);
      check(!cpu_ready, "R10 ready single cycle", cpu_ready, 0);
      if (hold) begin
         repeat (2) begin
            @(negedge clk);
            check(bus_ior_n && !cpu_ready, "R11 held request ignored", {bus_ior_n, cpu_ready}, 2);
         end
      end
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cpu_req = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(bus_ior_n && !cpu_ready && cpu_rdata == 16'h0, "R1 reset state",
               {bus_ior_n, cpu_ready, cpu_rdata}, 32'h20000);
      end
      cpu_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int a = 0; a < (1 << AW); a++) begin
         for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 2; f++) begin
               run_tx(a, m[0], f[0], (a % 4) == 3);
            end
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule